// File: doc/BRIEF.md
# Unified Data Address Space with Frame-Buffer Tap

This block is the whole data-side address space of a small 16-bit processor. It sits behind one word address port. Inside are a general-purpose RAM that fills the lower half of the space, a frame-buffer RAM that fills the next quarter, and a single read-only word that shows the current keyboard code. The processor reads any location combinationally and writes with a load strobe. A write commits on the clock edge, so the new word shows up on the read bus in the following cycle.

A second read-only port, with its own index, gives a display reader direct access to the frame buffer. Addresses above the keyboard word are invalid. They read as zero, and writes to them are dropped. The address width `ADDR_W` sets the map: RAM takes 2^(ADDR_W-1) words, the frame buffer takes 2^(ADDR_W-2) words, and the keyboard word sits at 3·2^(ADDR_W-2). With `ADDR_W` = 15 this is 0x0000–0x3FFF for RAM, 0x4000–0x5FFF for the frame buffer and 0x6000 for the keyboard. The default `ADDR_W` = 12 keeps elaboration small. At that width the map is 0x000–0x7FF for RAM, 0x800–0xBFF for the frame buffer and 0xC00 for the keyboard, with 0xC01–0xFFF invalid. Storage has no reset and holds zeros at start-up.

Top module: `mem_map_space`

## Requirements
- R1: An address with its top bit 0 selects general RAM word `addr_i[ADDR_W-2:0]`, which can be read and written.
- R2: `rdata_o` follows `addr_i` combinationally, within the same cycle and with no clock edge in between.
- R3: With `load_i` high at a rising edge, `wdata_i` is stored at that cycle's address. The read bus still shows the old word before the edge and shows the new word from the next cycle.
- R4: Addresses from 2^(ADDR_W-1) to 3·2^(ADDR_W-2)-1 select frame-buffer word (address − 2^(ADDR_W-1)). A word written there through the main port reads back on the display port at that index.
- R5: The address 3·2^(ADDR_W-2) reads `kbd_code_i` combinationally.
- R6: A write to the keyboard address changes no stored word, and the keyboard address still reads `kbd_code_i`.
- R7: Any address above the keyboard address reads as zero.
- R8: A write to an invalid address changes no RAM or frame-buffer word, including the words whose index matches the address's low bits.
- R9: All RAM and frame-buffer words read zero before their first write.
- R10: `fb_rdata_o` shows frame-buffer word `fb_addr_i` combinationally, independently of the main port's address at the same time.
- R11: With `load_i` low, no stored word changes, whatever `wdata_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on its rising edge |
| load_i | input | 1 | Write strobe for the main port |
| addr_i | input | ADDR_W | Main-port word address |
| wdata_i | input | DATA_W | Main-port write data |
| kbd_code_i | input | DATA_W | Current keyboard code |
| rdata_o | output | DATA_W | Main-port read data (combinational) |
| fb_addr_i | input | ADDR_W-2 | Display-port frame-buffer index |
| fb_rdata_o | output | DATA_W | Display-port read data (combinational) |

## Verification
A wrong region decision shows up on `rdata_o` in the same cycle: a boundary address returns a neighbour region's word, a keyboard code, or a non-zero value where zero is required. A misrouted write enable or a misrouted index does not show up at once. It appears only in a later cycle, when the aliased word is read back, so the bench reads back the words that share low address bits with each keyboard or invalid write, through both ports. A write that commits one cycle late, or early, is caught by sampling just before the edge and again in the cycle after it.

// File: rtl/mem_map_pkg.sv
package mem_map_pkg;
  typedef enum logic [1:0] {
    REG_RAM  = 2'd0,
    REG_FB   = 2'd1,
    REG_KBD  = 2'd2,
    REG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/mem_map_decode.sv
module mem_map_decode
  import mem_map_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [ADDR_W-2:0] ram_idx_o,
  output logic [ADDR_W-3:0] fb_idx_o
);
  // base offsets are powers of two, so region-relative index is a bit slice
  assign ram_idx_o = addr_i[ADDR_W-2:0];
  assign fb_idx_o  = addr_i[ADDR_W-3:0];

  always_comb begin
    if (!addr_i[ADDR_W-1])              region_o = REG_RAM;
    else if (!addr_i[ADDR_W-2])         region_o = REG_FB;
    else if (addr_i[ADDR_W-3:0] == '0)  region_o = REG_KBD;
    else                                region_o = REG_NONE;
  end
endmodule

// File: rtl/mem_map_bank.sv
module mem_map_bank #(
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 10,
  parameter int RD_PORTS = 1,
  localparam int DEPTH   = 1 << IDX_W
) (
  input  logic                               clk_i,
  input  logic                               we_i,
  input  logic [IDX_W-1:0]                   widx_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]     ridx_i,
  output logic [RD_PORTS-1:0][DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH] = '{default: '0};

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdata_o[p] = mem_q[ridx_i[p]];
  end
endmodule

// File: rtl/mem_map_space.sv
module mem_map_space
  import mem_map_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] kbd_code_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [ADDR_W-3:0] fb_addr_i,
  output logic [DATA_W-1:0] fb_rdata_o
);
  localparam int RAM_IW = ADDR_W - 1;
  localparam int FB_IW  = ADDR_W - 2;

  region_e                         region;
  logic [RAM_IW-1:0]               ram_idx;
  logic [FB_IW-1:0]                fb_idx;
  logic [0:0][DATA_W-1:0]          ram_rd;
  logic [1:0][DATA_W-1:0]          fb_rd;
  logic [1:0][FB_IW-1:0]           fb_ridx;
  logic                            ram_we;
  logic                            fb_we;

  mem_map_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .region_o  (region),
    .ram_idx_o (ram_idx),
    .fb_idx_o  (fb_idx)
  );

  assign ram_we = load_i && (region == REG_RAM);
  assign fb_we  = load_i && (region == REG_FB);

  mem_map_bank #(.DATA_W(DATA_W), .IDX_W(RAM_IW), .RD_PORTS(1)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .widx_i  (ram_idx),
    .wdata_i (wdata_i),
    .ridx_i  (ram_idx),
    .rdata_o (ram_rd)
  );

  // port 0: main bus, port 1: display reader
  assign fb_ridx[0] = fb_idx;
  assign fb_ridx[1] = fb_addr_i;

  mem_map_bank #(.DATA_W(DATA_W), .IDX_W(FB_IW), .RD_PORTS(2)) u_fb (
    .clk_i   (clk_i),
    .we_i    (fb_we),
    .widx_i  (fb_idx),
    .wdata_i (wdata_i),
    .ridx_i  (fb_ridx),
    .rdata_o (fb_rd)
  );

  always_comb begin
    unique case (region)
      REG_RAM: rdata_o = ram_rd[0];
      REG_FB:  rdata_o = fb_rd[0];
      REG_KBD: rdata_o = kbd_code_i;
      default: rdata_o = '0;
    endcase
  end

  assign fb_rdata_o = fb_rd[1];
endmodule

// File: rtl/mem_map_space_chk.sv
module mem_map_space_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] kbd_code_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [ADDR_W-3:0] fb_addr_i,
  input logic [DATA_W-1:0] fb_rdata_o
);
  localparam logic [ADDR_W-1:0] FB_BASE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] KBD_A   = ADDR_W'(3) << (ADDR_W - 2);

  logic live_q = 1'b0;
  always_ff @(posedge clk_i) live_q <= 1'b1;

  logic [ADDR_W-1:0] fb_off;
  logic              fb_hit;
  assign fb_off = addr_i - FB_BASE;
  assign fb_hit = (addr_i >= FB_BASE) && (addr_i < KBD_A) &&
                  (fb_off[ADDR_W-3:0] == fb_addr_i);

  // R5
  kbd_read_chk: assert property (@(posedge clk_i) disable iff (!live_q)
    (addr_i == KBD_A) |-> (rdata_o == kbd_code_i));

  // R7
  invalid_read_chk: assert property (@(posedge clk_i) disable iff (!live_q)
    (addr_i > KBD_A) |-> (rdata_o == '0));

  // R3
  write_visible_chk: assert property (@(posedge clk_i) disable iff (!live_q)
    (load_i && addr_i < KBD_A) |=>
      ((addr_i != $past(addr_i)) || (rdata_o == $past(wdata_i))));

  // R4
  fb_tap_chk: assert property (@(posedge clk_i) disable iff (!live_q)
    (load_i && fb_hit) |=>
      ((fb_addr_i != $past(fb_addr_i)) || (fb_rdata_o == $past(wdata_i))));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!live_q)
    (!load_i && addr_i < KBD_A) |=>
      ((addr_i != $past(addr_i)) || (rdata_o == $past(rdata_o))));
endmodule

bind mem_map_space mem_map_space_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .load_i     (load_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .kbd_code_i (kbd_code_i),
  .rdata_o    (rdata_o),
  .fb_addr_i  (fb_addr_i),
  .fb_rdata_o (fb_rdata_o)
);

// File: tb/test_mem_map_space.sv
module test_mem_map_space;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] kbd = '0;
  logic [DW-1:0] rdata;
  logic [AW-3:0] fb_addr = '0;
  logic [DW-1:0] fb_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mem_map_space #(.ADDR_W(AW), .DATA_W(DW)) i_mem_map_space (
    .clk_i      (clk),
    .load_i     (load),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .kbd_code_i (kbd),
    .rdata_o    (rdata),
    .fb_addr_i  (fb_addr),
    .fb_rdata_o (fb_rdata)
  );

  typedef struct packed {
    logic          ld;
    logic [AW-1:0] a;
    logic [DW-1:0] wd;
    logic [DW-1:0] kb;
    logic [AW-3:0] fa;
    logic [DW-1:0] erd;
    logic [DW-1:0] efb;
    logic [7:0]    req;
  } vec_t;

  // expected values are sampled just before the rising edge of each row
  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 16'h0000, 16'h0000, 10'h000, 16'h0000, 16'h0000, 8'd9},  // R9
    '{1'b1, 12'h000, 16'hA001, 16'h0000, 10'h000, 16'h0000, 16'h0000, 8'd3},  // R3 old value
    '{1'b1, 12'h7FF, 16'hA7FF, 16'h0000, 10'h000, 16'h0000, 16'h0000, 8'd1},  // R1
    '{1'b1, 12'h800, 16'hB800, 16'h0000, 10'h000, 16'h0000, 16'h0000, 8'd4},  // R4
    '{1'b1, 12'hBFF, 16'hBBFF, 16'h0000, 10'h3FF, 16'h0000, 16'h0000, 8'd4},  // R4
    '{1'b1, 12'hC00, 16'hC0C0, 16'h1234, 10'h000, 16'h1234, 16'hB800, 8'd5},  // R5
    '{1'b1, 12'hC01, 16'hDEAD, 16'h1234, 10'h000, 16'h0000, 16'hB800, 8'd7},  // R7
    '{1'b1, 12'hFFF, 16'hBEEF, 16'h1234, 10'h000, 16'h0000, 16'hB800, 8'd7},  // R7
    '{1'b0, 12'h000, 16'h0000, 16'h1234, 10'h000, 16'hA001, 16'hB800, 8'd1},  // R1
    '{1'b0, 12'h7FF, 16'h0000, 16'h1234, 10'h3FF, 16'hA7FF, 16'hBBFF, 8'd10}, // R10
    '{1'b0, 12'h800, 16'h0000, 16'h1234, 10'h3FF, 16'hB800, 16'hBBFF, 8'd4},  // R4
    '{1'b0, 12'hBFF, 16'h0000, 16'h1234, 10'h000, 16'hBBFF, 16'hB800, 8'd10}, // R10
    '{1'b0, 12'hC00, 16'h0000, 16'h00FF, 10'h000, 16'h00FF, 16'hB800, 8'd6},  // R6
    '{1'b0, 12'hC01, 16'h0000, 16'h00FF, 10'h001, 16'h0000, 16'h0000, 8'd8},  // R8
    '{1'b0, 12'hFFF, 16'h0000, 16'h00FF, 10'h3FF, 16'h0000, 16'hBBFF, 8'd8},  // R8
    '{1'b0, 12'h001, 16'h0000, 16'h00FF, 10'h001, 16'h0000, 16'h0000, 8'd8},  // R8 alias
    '{1'b0, 12'h401, 16'h0000, 16'h00FF, 10'h3FE, 16'h0000, 16'h0000, 8'd8},  // R8 alias
    '{1'b0, 12'h400, 16'h0000, 16'h00FF, 10'h000, 16'h0000, 16'hB800, 8'd6},  // R6 alias
    '{1'b1, 12'h100, 16'h1111, 16'h00FF, 10'h000, 16'h0000, 16'hB800, 8'd3},  // R3
    '{1'b0, 12'h100, 16'h2222, 16'h00FF, 10'h000, 16'h1111, 16'hB800, 8'd11}, // R11
    '{1'b0, 12'h100, 16'h3333, 16'h00FF, 10'h000, 16'h1111, 16'hB800, 8'd11}  // R11
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load = VECS[i].ld; addr = VECS[i].a; wdata = VECS[i].wd;
      kbd = VECS[i].kb; fb_addr = VECS[i].fa;
      #2;
      check($sformatf("R%0d row %0d rdata", VECS[i].req, i), rdata, VECS[i].erd);
      check($sformatf("R%0d row %0d fb_rdata", VECS[i].req, i), fb_rdata, VECS[i].efb);
    end

    // R2: address change inside one cycle, no edge in between
    @(negedge clk);
    load = 1'b0; addr = 12'h000; #1;
    check("R2 addr 000", rdata, 16'hA001);
    addr = 12'h7FF; #1;
    check("R2 addr 7FF", rdata, 16'hA7FF);
    addr = 12'hC00; kbd = 16'h5A5A; #1;
    check("R2 kbd follow", rdata, 16'h5A5A);
    kbd = 16'hA5A5; #1;
    check("R5 kbd change", rdata, 16'hA5A5);

    // R10: display port sees a main-port frame-buffer write one cycle later
    @(negedge clk);
    load = 1'b1; addr = 12'h900; wdata = 16'h5555; fb_addr = 10'h100; #2;
    check("R10 before edge", fb_rdata, 16'h0000);
    @(negedge clk);
    load = 1'b0; addr = 12'h7FF; #2;
    check("R10 after edge", fb_rdata, 16'h5555);
    check("R10 main port independent", rdata, 16'hA7FF);
    addr = 12'h900; #1;
    check("R4 main read of 900", rdata, 16'h5555);

    @(negedge clk);
    finish_run();
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule